// File: doc/BRIEF.md
# Multicore Startup Wake-up Controller

This block decides which cores of a small symmetric multiprocessor are allowed to fetch once reset is released. Core 0 is the bootstrap core. It comes out of reset running, and its first fetch address is fixed at 0xFFFFFFF0. Every other core powers up asleep: its run enable is low and it fetches nothing.

Software on the bootstrap core wakes the other cores one at a time. It posts a startup request on a valid/ready port. The request names a target core index and a 32-bit start address. If the target is still asleep, it starts running in the next cycle, and that address is its first fetch. Each core can therefore begin at its own code location. A request that cannot take effect is discarded. Such a request targets a core that is already running, including the bootstrap core itself. Each discard sets a sticky per-core error bit. The per-core run enables also serve as the sleep/run status readback.

Top module: `core_wake_ctrl`

## Requirements
- R1: Once reset is released, `run_en[0]` is 1 and slice 0 of `start_pc` (bits 31:0) reads 0xFFFFFFF0. Every other `run_en` bit is 0, and every `drop_err` bit is 0.
- R2: `req_ready` is always 1. A request is accepted in every cycle in which `req_valid` is 1, at most one per cycle.
- R3: A request accepted at a clock edge for a sleeping core k (1 ≤ k < NUM_CORES) has the following effect after that same edge: `run_en[k]` reads 1, and slice k of `start_pc` (bits 32k+31:32k) holds the request address.
- R4: While a core runs, its `start_pc` slice never changes. Waking one core leaves the `run_en` bit and `start_pc` slice of every other core unchanged.
- R5: A request to a core that is already running, including core 0, is discarded. That core's `run_en` bit and `start_pc` slice are unchanged, and its `drop_err` bit reads 1 after the accepting edge.
- R6: A `drop_err` bit, once set, stays set until reset.
- R7: A request whose core index is NUM_CORES or greater changes no output.
- R8: A reset applied after wake-ups returns every non-bootstrap core to sleeping, clears all `drop_err` bits and reloads 0xFFFFFFF0 into slice 0.
- R9: The `start_pc` slice of a sleeping core reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Startup request present |
| req_ready | output | 1 | Request can be taken (always 1) |
| req_core | input | $clog2(NUM_CORES) | Target core index |
| req_addr | input | 32 | Start address for the target core |
| run_en | output | NUM_CORES | Per-core run enable; also the sleep/run status |
| start_pc | output | NUM_CORES*32 | Per-core start address, core k in bits 32k+31:32k |
| drop_err | output | NUM_CORES | Sticky per-core flag for discarded requests |

## Verification
The bench builds the controller with NUM_CORES set to 3. That gives a two-bit index that can still encode 3, so out-of-range requests can be driven. It also leaves two wakeable cores, so waking one while the other is observed, and retargeting a core that is already awake, can both be tested. Back-to-back requests with `req_valid` held high cover acceptance in consecutive cycles. A second reset after the wake-ups shows that every core's state is restored.

// File: rtl/wake_pkg.sv
package wake_pkg;

    localparam int ADDR_W      = 32;
    localparam int MAX_CORES   = 8;
    localparam int IDX_MAX_W   = 3;
    localparam logic [ADDR_W-1:0] BOOT_VECTOR = 32'hFFFF_FFF0;

    typedef enum logic {
        CORE_SLEEP = 1'b0,
        CORE_RUN   = 1'b1
    } core_state_e;

    typedef struct packed {
        logic                  valid;
        logic [IDX_MAX_W-1:0]  core;
        logic [ADDR_W-1:0]     addr;
    } wake_req_t;

    function automatic logic targets(input wake_req_t r, input int idx);
        return r.valid && (int'(r.core) == idx);
    endfunction

endpackage

// File: rtl/wake_req_decode.sv
module wake_req_decode
    import wake_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  wake_req_t              req,
    output logic [NUM_CORES-1:0]   hit
);

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_hit
        always_comb hit[g] = targets(req, g);
    end

endmodule

// File: rtl/wake_core_slot.sv
module wake_core_slot
    import wake_pkg::*;
#(
    parameter bit IS_BOOT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit,
    input  logic [ADDR_W-1:0] addr,
    output logic              run,
    output logic [ADDR_W-1:0] pc,
    output logic              err
);

    core_state_e       state;
    logic [ADDR_W-1:0] pc_q;
    logic              err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= IS_BOOT ? CORE_RUN : CORE_SLEEP;
            pc_q  <= IS_BOOT ? BOOT_VECTOR : '0;
            err_q <= 1'b0;
        end else if (hit) begin
            if (state == CORE_SLEEP) begin
                state <= CORE_RUN;
                pc_q  <= addr;
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    assign run = (state == CORE_RUN);
    assign pc  = pc_q;
    assign err = err_q;

endmodule

// File: rtl/core_wake_ctrl.sv
module core_wake_ctrl
    import wake_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic [IDX_W-1:0]              req_core,
    input  logic [ADDR_W-1:0]             req_addr,
    output logic [NUM_CORES-1:0]          run_en,
    output logic [NUM_CORES*ADDR_W-1:0]   start_pc,
    output logic [NUM_CORES-1:0]          drop_err
);

    wake_req_t            req_s;
    logic [NUM_CORES-1:0] hit;

    assign req_ready = 1'b1;

    always_comb begin
        req_s                  = '0;
        req_s.valid            = req_valid & req_ready;
        req_s.core[IDX_W-1:0]  = req_core;
        req_s.addr             = req_addr;
    end

    wake_req_decode #(.NUM_CORES(NUM_CORES)) u_dec (
        .req (req_s),
        .hit (hit)
    );

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_core
        wake_core_slot #(.IS_BOOT(g == 0)) u_slot (
            .clk  (clk),
            .rst  (rst),
            .hit  (hit[g]),
            .addr (req_s.addr),
            .run  (run_en[g]),
            .pc   (start_pc[g*ADDR_W +: ADDR_W]),
            .err  (drop_err[g])
        );
    end

endmodule

// File: rtl/wake_ctrl_checker.sv
module wake_ctrl_checker
    import wake_pkg::*;
#(
    parameter int NUM_CORES = 4,
    localparam int IDX_W    = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        req_valid,
    input logic                        req_ready,
    input logic [IDX_W-1:0]            req_core,
    input logic [ADDR_W-1:0]           req_addr,
    input logic [NUM_CORES-1:0]        run_en,
    input logic [NUM_CORES*ADDR_W-1:0] start_pc,
    input logic [NUM_CORES-1:0]        drop_err
);

    logic acc;
    assign acc = req_valid && req_ready;

    always @(negedge clk) begin
        if (!rst) assert_ready_high_R2: assert (req_ready);
    end

    assert_boot_runs_R1: assert property (@(posedge clk) disable iff (rst)
        run_en[0] && start_pc[ADDR_W-1:0] == BOOT_VECTOR);

    assert_bad_index_R7: assert property (@(posedge clk) disable iff (rst)
        acc && int'(req_core) >= NUM_CORES |=>
            $stable(run_en) && $stable(drop_err) && $stable(start_pc));

    for (genvar g = 0; g < NUM_CORES; g++) begin : g_chk
        assert_stays_running_R4: assert property (@(posedge clk) disable iff (rst)
            run_en[g] |=> run_en[g] && $stable(start_pc[g*ADDR_W +: ADDR_W]));

        assert_wake_R3: assert property (@(posedge clk) disable iff (rst)
            acc && int'(req_core) == g && !run_en[g] |=>
                run_en[g] && start_pc[g*ADDR_W +: ADDR_W] == $past(req_addr));

        assert_only_target_wakes_R4: assert property (@(posedge clk) disable iff (rst)
            $rose(run_en[g]) |-> $past(acc) && int'($past(req_core)) == g);

        assert_drop_flag_R5: assert property (@(posedge clk) disable iff (rst)
            acc && int'(req_core) == g && run_en[g] |=> drop_err[g]);

        assert_sticky_err_R6: assert property (@(posedge clk) disable iff (rst)
            drop_err[g] |=> drop_err[g]);

        assert_sleep_pc_zero_R9: assert property (@(posedge clk) disable iff (rst)
            !run_en[g] |-> start_pc[g*ADDR_W +: ADDR_W] == '0);
    end

endmodule

bind core_wake_ctrl wake_ctrl_checker #(.NUM_CORES(NUM_CORES)) u_wake_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_core  (req_core),
    .req_addr  (req_addr),
    .run_en    (run_en),
    .start_pc  (start_pc),
    .drop_err  (drop_err)
);

// File: tb/test_core_wake_ctrl.sv
`timescale 1ns/1ps
module test_core_wake_ctrl;

    localparam int N     = 3;
    localparam int IDX_W = 2;
    localparam int AW    = 32;
    localparam int EW    = 2*N + N*AW;
    localparam logic [AW-1:0] BOOT = 32'hFFFF_FFF0;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [IDX_W-1:0] req_core = '0;
    logic [AW-1:0]   req_addr = '0;
    logic [N-1:0]    run_en;
    logic [N*AW-1:0] start_pc;
    logic [N-1:0]    drop_err;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [N-1:0]    m_run;
    logic [N-1:0]    m_err;
    logic [N*AW-1:0] m_pc;

    logic [EW-1:0] exp_q[$];
    string         tag_q[$];

    always #2.5 clk = ~clk;

    core_wake_ctrl #(.NUM_CORES(N)) i_core_wake_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_core  (req_core),
        .req_addr  (req_addr),
        .run_en    (run_en),
        .start_pc  (start_pc),
        .drop_err  (drop_err)
    );

    task automatic model_reset();
        m_run = '0; m_run[0] = 1'b1;
        m_err = '0;
        m_pc  = '0; m_pc[AW-1:0] = BOOT;
    endtask

    task automatic push(input string tag);
        exp_q.push_back({m_run, m_err, m_pc});
        tag_q.push_back(tag);
    endtask

    task automatic do_reset(input string tag);
        @(negedge clk);
        rst = 1'b1; req_valid = 1'b0;
        model_reset();
        push(tag);
        @(negedge clk);
        push(tag);
        @(negedge clk);
        rst = 1'b0;
        push(tag);
    endtask

    task automatic send(input int idx, input logic [AW-1:0] addr, input string tag);
        @(negedge clk);
        checks++;
        if (req_ready !== 1'b1) begin
            errors++;
            $display("FAIL R2 req_ready actual %b expected 1", req_ready);
        end
        req_valid = 1'b1;
        req_core  = IDX_W'(idx);
        req_addr  = addr;
        if (idx < N) begin
            if (!m_run[idx]) begin
                m_run[idx] = 1'b1;
                m_pc[idx*AW +: AW] = addr;
            end else begin
                m_err[idx] = 1'b1;
            end
        end
        push(tag);
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        req_valid = 1'b0;
        req_addr  = 32'hDEAD_BEEF;
        push(tag);
    endtask

    // monitor: compares the outputs just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [EW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if ({run_en, drop_err, start_pc} !== e) begin
                    errors++;
                    $display("FAIL %s run/err/pc actual %h_%h_%h expected %h_%h_%h",
                             t, run_en, drop_err, start_pc,
                             e[EW-1 -: N], e[EW-N-1 -: N], e[N*AW-1:0]);
                end
            end
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset("R1 reset state");
        idle("R9 sleeping pc zero");
        send(1, 32'h0000_1000, "R3 wake core1");
        idle("R4 core2 untouched");
        send(2, 32'h0008_2000, "R3 wake core2");
        idle("R4 pc stable");
        send(1, 32'h3333_3333, "R5 retarget running core1");
        idle("R6 sticky core1");
        send(0, 32'h4444_0000, "R5 request to boot core");
        idle("R6 sticky core0");
        send(3, 32'h5555_5555, "R7 out of range index");
        idle("R7 no change");
        do_reset("R8 reset after wakes");
        idle("R8 all asleep");
        send(2, 32'h0000_0040, "R3 wake core2 after reset");
        send(2, 32'h0000_0080, "R5 back to back same core");
        send(1, 32'h0000_00C0, "R2 back to back other core");
        idle("R6 R4 final");
        idle("R4 final hold");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule